// File: doc/BRIEF.md
# I2C Target with Byte Registers and Streamed Coefficient Words

This block is a serial-bus target for a control interface. It holds a small file of byte-wide settings and four banks of 32-bit coefficient words: three for audio channels and one for an equalizer. The controller reaches everything through the usual I2C framing. A write sends the device address with the write bit, a subaddress byte and then data bytes. A read sends the device address with the write bit and the subaddress, then a repeated START, then the device address with the read bit, after which the target returns data until the controller answers a byte with NAK and ends with STOP.

A mode register at subaddress 0x7E decides what the subaddress means. With mode 0x00, or any value that is not one of the word-mode codes, accesses are single bytes to the settings file and the subaddress advances after each byte. With a one-hot word-mode code, the subaddress is a word index into the chosen bank. Each word then moves as four bytes, bits 31:24 first, and consecutive words follow one another in the same transaction. Code 0x03 writes a word into the channel 1 and channel 2 banks at once.

SCL and SDA are brought into the system clock through two-flop synchronizers. The system clock must run at least eight times faster than SCL. The target only pulls SDA low through an open-drain enable.

Top module: `i2c_coef_target`

## Requirements
- R1: A byte after START whose upper seven bits equal DEV_ADDR (default 0x34) is acknowledged by SDA low in the ninth clock. A byte with any other address is not acknowledged, and the target drives nothing until the next START.
- R2: In byte mode, written data bytes land in the settings register at subaddress modulo 16, and reads return them. The subaddress increases by one after every byte, whether written or read.
- R3: The mode register sits at subaddress 0x7E and resets to 0x00. It can be written and read back as a single byte under every mode value.
- R4: Mode codes 0x01, 0x02, 0x04 and 0x08 select the channel 1, channel 2, channel 3 and equalizer banks. Word reads return bits 31:24, 23:16, 15:8 and 7:0 in that order. Word writes take four bytes in the same order and store the word after the fourth byte.
- R5: In word mode, the subaddress modulo DEPTH (default 8) sets the starting word index. The index advances by one after each fourth byte and wraps from DEPTH-1 to 0, so words stream back to back.
- R6: Under mode 0x03, a written word is stored in both the channel 1 and channel 2 banks at the same index. Reads under this mode come from the channel 1 bank.
- R7: Any mode value other than 0x00, 0x01, 0x02, 0x03, 0x04 or 0x08 makes reads and writes behave as in byte mode.
- R8: After the controller answers a read byte with NAK, the target keeps SDA released until the next START.
- R9: The target changes its SDA drive only while the synchronized SCL is low.
- R10: After reset, SDA is released and every settings register and coefficient word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Each bus event reaches the sequencer two synchronizer stages and one edge-detect stage after the pin changes. Every SDA drive from the target is therefore in place about four system cycles after the SCL falling edge that causes it, whether it is an ACK or a read data bit. The bench's master keeps every SCL phase forty nanoseconds (ten system cycles) or longer. It samples acknowledges and read bits halfway through the SCL high phase, well after that latency, and moves its own SDA only a quarter period after SCL falls. Written bytes and words are stored during the ACK of the byte that completes them. Read-back transactions therefore start after the write's STOP and see the new contents. A scoreboard compares every returned byte, in order, with the byte queued when the read was issued.

// File: rtl/i2c_coef_pkg.sv
package i2c_coef_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;

  localparam int          NBANK        = 4;
  localparam logic [7:0]  MODE_SUBADDR = 8'h7E;

  // Word-mode codes: one bit per bank, plus the dual channel code.
  function automatic logic mode_is_word(input logic [7:0] m);
    return (m == 8'h01) || (m == 8'h02) || (m == 8'h03) ||
           (m == 8'h04) || (m == 8'h08);
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  // Two synchronizer stages plus one history stage per line.
  logic [2:0] scl_sh_q, sda_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= 3'b111;
      sda_sh_q <= 3'b111;
    end else begin
      scl_sh_q <= {scl_sh_q[1:0], scl_i};
      sda_sh_q <= {sda_sh_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_sh_q[1];
  assign sda_o      = sda_sh_q[1];
  assign scl_rise_o = scl_sh_q[1] & ~scl_sh_q[2];
  assign scl_fall_o = ~scl_sh_q[1] & scl_sh_q[2];
  assign start_o    = scl_sh_q[1] & scl_sh_q[2] & ~sda_sh_q[1] & sda_sh_q[2];
  assign stop_o     = scl_sh_q[1] & scl_sh_q[2] & sda_sh_q[1] & ~sda_sh_q[2];

endmodule

// File: rtl/i2c_coef_store.sv
module i2c_coef_store
  import i2c_coef_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  localparam int RW   = $clog2(NREG),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    sub,
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    wb,
  output logic          word_acc_o,
  output logic [7:0]    rd_byte_o
);

  logic [7:0]  mode_q;
  logic [7:0]  reg_q  [NREG];
  logic [31:0] bank_q [NBANK][DEPTH];
  logic [23:0] acc_q;
  logic [NBANK-1:0] bank_we;
  logic [1:0]  rd_bank;
  logic [31:0] rd_word;
  logic        byte_we;

  assign word_acc_o = mode_is_word(mode_q) && (sub != MODE_SUBADDR);
  assign byte_we    = wr_en && !word_acc_o;

  // One write enable per bank, taken from the matching mode bit.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank_we
    assign bank_we[b] = wr_en && word_acc_o && (wb == 2'd3) && mode_q[b];
  end

  // Lowest set mode bit picks the read bank (0x03 reads channel 1).
  always_comb begin
    rd_bank = 2'd0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (mode_q[b]) rd_bank = 2'(b);
    end
  end

  assign rd_word = bank_q[rd_bank][ptr];

  always_comb begin
    if (word_acc_o)                 rd_byte_o = 8'(rd_word >> {~wb, 3'b000});
    else if (sub == MODE_SUBADDR)   rd_byte_o = mode_q;
    else                            rd_byte_o = reg_q[sub[RW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00;
      for (int i = 0; i < NREG; i++) reg_q[i] <= 8'h00;
    end else if (byte_we) begin
      if (sub == MODE_SUBADDR) mode_q <= wr_data;
      else                     reg_q[sub[RW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    acc_q <= 24'h0;
    else if (wr_en && word_acc_o)  acc_q <= {acc_q[15:0], wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < DEPTH; w++) bank_q[b][w] <= 32'h0;
    end else begin
      for (int b = 0; b < NBANK; b++)
        if (bank_we[b]) bank_q[b][ptr] <= {acc_q, wr_data};
    end
  end

  // R6: a dual-channel word write leaves both banks equal at that index.
  p_pair_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we[0] && bank_we[1]) |=> (bank_q[0][$past(ptr)] == bank_q[1][$past(ptr)]));

endmodule

// File: rtl/i2c_coef_target.sv
module i2c_coef_target
  import i2c_coef_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         NREG     = 16,
  parameter int         DEPTH    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int            AW       = $clog2(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  i2c_bus_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  tgt_state_e    state_q, state_d, nxt_q, nxt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          oe_q, oe_d;
  logic [7:0]    sub_q, sub_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [1:0]    wb_q, wb_d;
  logic          flag_q, flag_d;
  logic          wr_en, adv, word_acc;
  logic [7:0]    rd_byte;

  i2c_coef_store #(.NREG(NREG), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (sh_q),
    .sub        (sub_q),
    .ptr        (ptr_q),
    .wb         (wb_q),
    .word_acc_o (word_acc),
    .rd_byte_o  (rd_byte)
  );

  always_comb begin
    state_d = state_q;
    nxt_d   = nxt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    sub_d   = sub_q;
    ptr_d   = ptr_q;
    wb_d    = wb_q;
    flag_d  = flag_q;
    wr_en   = 1'b0;
    adv     = 1'b0;
    if (start) begin
      state_d = ST_ADDR;
      bit_d   = 3'd0;
      flag_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
      flag_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) flag_d = 1'b1;
          end else if (scl_fall && flag_q) begin
            flag_d = 1'b0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_d    = 1'b1;
                state_d = ST_ACK;
                nxt_d   = sh_q[0] ? ST_TX : ST_SUB;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_SUB) begin
              sub_d   = sh_q;
              ptr_d   = AW'(sh_q % DEPTH);
              wb_d    = 2'd0;
              oe_d    = 1'b1;
              state_d = ST_ACK;
              nxt_d   = ST_WDATA;
            end else begin
              wr_en   = 1'b1;
              adv     = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_ACK;
              nxt_d   = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = nxt_q;
            bit_d   = 3'd0;
            if (nxt_q == ST_TX) begin
              sh_d = rd_byte;
              oe_d = ~rd_byte[7];
            end else begin
              oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            adv = 1'b1;
            if (sda_s) state_d = ST_IDLE;
            else       flag_d  = 1'b1;
          end else if (scl_fall && flag_q) begin
            flag_d  = 1'b0;
            state_d = ST_TX;
            bit_d   = 3'd0;
            sh_d    = rd_byte;
            oe_d    = ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
    if (adv) begin
      if (word_acc) begin
        wb_d = wb_q + 2'd1;
        if (wb_q == 2'd3) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + AW'(1);
      end else begin
        sub_d = sub_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      bit_q   <= 3'd0;
      sh_q    <= 8'h00;
      oe_q    <= 1'b0;
      sub_q   <= 8'h00;
      ptr_q   <= '0;
      wb_q    <= 2'd0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      sub_q   <= sub_d;
      ptr_q   <= ptr_d;
      wb_q    <= wb_d;
      flag_q  <= flag_d;
    end
  end

  assign sda_oe_o = oe_q;

  // R9: the drive only moves after a cycle in which SCL was seen low.
  p_sda_move_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_s));

  // R1: an unmatched address leaves the line alone.
  p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q);

  // R8: after NAK or STOP the target is idle and released.
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  // R4: a read data bit holds through the SCL high phase.
  p_tx_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX && scl_s && $past(scl_s)) |-> $stable(oe_q));

endmodule

// File: tb/tb_i2c_coef_target.sv
`timescale 1ns/1ps
module tb_i2c_coef_target;

  localparam logic [6:0] DEV = 7'h34;
  localparam time        Q   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  wire  sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_coef_target dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int compared = 0;
  int mism     = 0;
  int r9_bad   = 0;
  bit done     = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  logic [7:0] wq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mism++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    end
  endtask

  // Monitor: pops each returned byte and its expectation.
  always @(negedge clk) begin
    if (got_q.size() != 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected read byte", g, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  // R9 monitor: drive must not move while SCL is high.
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && m_scl) r9_bad++;
    oe_prev = sda_oe;
  end

  task automatic expb(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic expw(input logic [31:0] w, input string tag);
    for (int i = 3; i >= 0; i--) expb(w[8*i +: 8], tag);
  endtask

  task automatic bstart();
    m_sda = 1'b1; #Q;
    m_scl = 1'b1; #Q;
    m_sda = 1'b0; #Q;
    m_scl = 1'b0; #Q;
  endtask

  task automatic bstop();
    m_sda = 1'b0; #Q;
    m_scl = 1'b1; #Q;
    m_sda = 1'b1; #(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q;
      m_scl = 1'b1; #(2*Q);
      m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q;
    m_scl = 1'b1; #Q;
    ack = !sda_line; #Q;
    m_scl = 1'b0; #Q;
  endtask

  task automatic recv(input bit nak, output logic [7:0] b);
    m_sda = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      #Q;
      m_scl = 1'b1; #Q;
      b = {b[6:0], sda_line}; #Q;
      m_scl = 1'b0;
    end
    #Q;
    m_sda = nak; #Q;
    m_scl = 1'b1; #(2*Q);
    m_scl = 1'b0; #Q;
  endtask

  // Driver: write the queued bytes starting at subaddress sub.
  task automatic wr(input logic [7:0] sub, input string tag);
    bit a;
    bstart();
    send({DEV, 1'b0}, a); chk(a, "R1 address ack on write", a, 1);
    send(sub, a);         chk(a, "R1 subaddress ack", a, 1);
    while (wq.size() != 0) begin
      send(wq.pop_front(), a);
      chk(a, tag, a, 1);
    end
    bstop();
  endtask

  // Driver: read n bytes from subaddress sub, NAK on the last one.
  task automatic rd(input logic [7:0] sub, input int n);
    bit a;
    logic [7:0] b;
    bstart();
    send({DEV, 1'b0}, a); chk(a, "R1 address ack before read", a, 1);
    send(sub, a);         chk(a, "R1 subaddress ack before read", a, 1);
    bstart();
    send({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv(i == n - 1, b);
      got_q.push_back(b);
    end
    #Q;
    chk(sda_oe == 1'b0, "R8 released after NAK", sda_oe, 0);
    bstop();
  endtask

  task automatic set_mode(input logic [7:0] m);
    wq = {m};
    wr(8'h7E, "R3 mode write ack");
  endtask

  initial begin
    bit a;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    #(4*Q);
    chk(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);

    // R3: mode register resets to zero
    expb(8'h00, "R3 mode reset value");
    rd(8'h7E, 1);

    // R2: byte registers, auto-increment, modulo 16
    wq = {8'hA1, 8'hB2, 8'hC3};
    wr(8'h02, "R2 data ack");
    expb(8'hA1, "R2 byte 0"); expb(8'hB2, "R2 byte 1"); expb(8'hC3, "R2 byte 2");
    rd(8'h02, 3);
    expb(8'hA1, "R2 subaddress modulo 16");
    rd(8'h12, 1);
    expb(8'h00, "R10 untouched register zero");
    rd(8'h09, 1);

    // R1: foreign address ignored until next START
    bstart();
    send({7'h13, 1'b0}, a); chk(!a, "R1 foreign address not acked", a, 0);
    send(8'h02, a);         chk(!a, "R1 silent until START", a, 0);
    bstop();

    // R4/R5: channel 1 words, streaming with wrap
    set_mode(8'h01);
    expb(8'h01, "R3 mode readback in word mode");
    rd(8'h7E, 1);
    wq = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88,
          8'h99, 8'hAA, 8'hBB, 8'hCC};
    wr(8'h06, "R4 word data ack");
    expw(32'h11223344, "R4 word MSB first");
    expw(32'h55667788, "R5 second word");
    expw(32'h99AABBCC, "R5 wrap to index 0");
    rd(8'h06, 12);
    expw(32'h55667788, "R5 index from subaddress modulo depth");
    expw(32'h99AABBCC, "R5 wrap after last index");
    rd(8'h0F, 8);

    // R4: channel 2 bank is separate
    set_mode(8'h02);
    expw(32'h00000000, "R4 channel 2 bank untouched");
    rd(8'h06, 4);

    // R6: dual channel write
    set_mode(8'h03);
    wq = {8'hDE, 8'hAD, 8'hBE, 8'hEF};
    wr(8'h02, "R6 word data ack");
    expw(32'hDEADBEEF, "R6 read under dual code");
    rd(8'h02, 4);
    set_mode(8'h02);
    expw(32'hDEADBEEF, "R6 copy in channel 2");
    rd(8'h02, 4);
    set_mode(8'h01);
    expw(32'hDEADBEEF, "R6 copy in channel 1");
    expw(32'h00000000, "R6 next index unchanged");
    rd(8'h02, 8);
    set_mode(8'h04);
    expw(32'h00000000, "R10 channel 3 bank zero");
    rd(8'h02, 4);

    // R4: equalizer bank
    set_mode(8'h08);
    wq = {8'hCA, 8'hFE, 8'hF0, 8'h0D};
    wr(8'h01, "R4 equalizer word ack");
    expw(32'hCAFEF00D, "R4 equalizer readback");
    rd(8'h01, 4);
    set_mode(8'h04);
    expw(32'h00000000, "R4 channel 3 not written by equalizer code");
    rd(8'h01, 4);

    // R7: unlisted mode falls back to byte mode
    set_mode(8'h05);
    expb(8'hA1, "R7 byte read under unlisted mode");
    expb(8'hB2, "R7 byte auto-increment under unlisted mode");
    rd(8'h02, 2);
    wq = {8'h5A};
    wr(8'h05, "R7 byte write ack");
    expb(8'h5A, "R7 byte write readback");
    rd(8'h05, 1);
    expb(8'h05, "R3 mode readback unlisted value");
    rd(8'h7E, 1);

    #(20*Q);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(r9_bad == 0, "R9 drive moved while SCL high", r9_bad, 0);
    summary();
    $finish;
  end

  initial begin
    #700000;
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

endmodule